// File: doc/BRIEF.md
# Parallel-Channel Logic Self-Test Sequencer

This block runs a random-pattern self-test on logic that has been split into a number of scan channels, all of the same length. A single 32-bit linear-feedback generator supplies one fresh bit to every channel on each shift. A single 32-bit multiple-input signature register folds the channel outputs into a running signature. For each pattern the sequencer fills every channel, fires a burst of at-speed capture cycles, and then shifts the captured responses out. That unload takes place in the same shift cycles that load the next pattern. One extra shift pass after the last pattern drains the final responses.

Shift pulses can be spaced out by a programmable number of idle cycles. Capture bursts always run at full clock rate. This lets slow scan and fast capture be set independently. A stop-after value ends the run early, after a chosen pattern, and leaves the signature of that prefix. Comparing prefix signatures against known-good values narrows down the first failing pattern by binary search. The logic under test and the expected signatures are outside the block.

Top module: `lbist_ctrl`

## Requirements
- R1: After reset, `done`, `scan_en` and `cap_en` are 0 and `signature` is 0.
- R2: The generator is a 32-bit shift-left register whose new bit 0 is s[31]^s[21]^s[1]^s[0]. It is loaded from `seed` on an accepted start, with a seed of 0 replaced by 1. During every shift, channel i receives generator bit i on `scan_in[i]`, and the generator advances once per shift.
- R3: A run makes patterns+1 shift passes of `chan_len` pulses of `scan_en` each. The first pass loads only and the last pass unloads only. A `pat_count` of 0 counts as 1 and a `chan_len` of 0 counts as 1.
- R4: The signature is cleared to 0 on an accepted start. On every shift except those of the first pass it becomes {sig[30:0], sig[31]^sig[21]^sig[1]^sig[0]} XOR `scan_out`, with `scan_out` zero-extended to 32 bits (channel i at bit i).
- R5: After each pass except the last, `cap_en` is high for exactly `cap_len` consecutive cycles (0 counts as 1). `cap_en` is never high together with `scan_en`.
- R6: Within a pass, consecutive `scan_en` pulses are exactly `shift_gap`+1 cycles apart. Capture bursts stay contiguous whatever the gap.
- R7: When `stop_after` is nonzero and below the effective pattern count, the run ends after that many patterns, including the unload-only pass. The signature then equals that of a full run with that many patterns.
- R8: `done` rises in the cycle after the last `scan_en` pulse. `done` and `signature` then hold, with no further shift or capture, until the next start. An accepted start clears `done`.
- R9: All settings and the seed are taken at an accepted start. Changing inputs or pulsing `start` while a run is in progress has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle or finished) |
| seed | input | 32 | Generator seed |
| pat_count | input | PAT_W | Number of patterns |
| stop_after | input | PAT_W | Stop after this pattern; 0 means run all |
| cap_len | input | CAP_W | Capture cycles per pattern |
| chan_len | input | LEN_W | Length of each channel in shifts |
| shift_gap | input | GAP_W | Idle cycles between shift pulses |
| scan_in | output | NUM_CH | Serial data into each channel |
| scan_out | input | NUM_CH | Serial data out of each channel |
| scan_en | output | 1 | Shift strobe for all channels |
| cap_en | output | 1 | Functional capture strobe |
| signature | output | 32 | Signature register value |
| done | output | 1 | Run finished; signature valid |

## Verification
The bench surrounds the block with a model of four channels whose capture step mixes each channel word with a rotated neighbour word and a position constant. This way both the load order and the capture count change the signature. A sweep runs every combination of one to three patterns, burst lengths 1, 2 and 4, channel lengths 1, 3 and 5, and shift gaps 0 and 2. The sweep separates errors in pass count, in burst length, in pulse spacing and in folding the first or last pass. Further runs cover a zero seed against seed 1, zero-valued settings, stop points below, at and above the pattern count, and inputs changed with a stray start pulse in the middle of a run.

// File: rtl/lbist_pkg.sv
// Shared constants, the feedback step and the sequencer state type for the
// self-test sequencer. Assumes 32-bit generator and signature registers.
package lbist_pkg;
    localparam int          LFSR_W    = 32;
    // Feedback taps at bits 31, 21, 1 and 0 (primitive degree-32 polynomial)
    localparam logic [31:0] FB_TAPS   = 32'h8020_0003;

    // One shift-left step with XOR feedback into bit 0
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], ^(s & FB_TAPS)};
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_CAPT  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/lbist_prpg.sv
// Pseudorandom pattern source: a 32-bit LFSR loaded with a nonzero seed and
// advanced once per shift; bit i feeds channel i.
// Assumes NUM_CH <= 32.
module lbist_prpg
    import lbist_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [31:0]       seed,
    input  logic              advance,
    output logic [NUM_CH-1:0] chan_bits
);
    logic [LFSR_W-1:0] state;

    // Register update: seed on load (zero replaced by 1), step on advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= 32'd1;
        else if (load)
            state <= (seed == 32'd0) ? 32'd1 : seed;
        else if (advance)
            state <= lfsr_step(state);
    end

    // Channel fan-out: one generator bit per channel
    for (genvar i = 0; i < NUM_CH; i++) begin : g_fan
        assign chan_bits[i] = state[i % LFSR_W];
    end

    // R2: the generator never collapses to the all-zero lock-up state
    a_r2_prpg_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state != 32'd0);
    // R2: every advance moves the generator to a new value
    a_r2_prpg_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> state != $past(state));
endmodule

// File: rtl/lbist_misr.sv
// Multiple-input signature register: a 32-bit LFSR step XORed with the
// channel outputs on each enabled cycle. Assumes NUM_CH <= 32.
module lbist_misr
    import lbist_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic [NUM_CH-1:0] din,
    output logic [31:0]       sig
);
    logic [LFSR_W-1:0] din_ext;

    // Zero-extend channel outputs to the register width
    always_comb begin
        din_ext = '0;
        din_ext[NUM_CH-1:0] = din;
    end

    // Signature update: clear on start, compress on enable
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            sig <= '0;
        else if (enable)
            sig <= lfsr_step(sig) ^ din_ext;
    end

    // R4: signature holds when neither cleared nor compressing
    a_r4_misr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !enable) |=> $stable(sig));
    // R4: a clear leaves the signature at zero
    a_r4_misr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> sig == 32'd0);
endmodule

// File: rtl/lbist_seq.sv
// Run sequencer: takes the settings at start, paces shift pulses by the
// programmed gap, fires capture bursts between passes and counts patterns,
// ending with one unload-only pass. Assumes settings are held only by start.
module lbist_seq
    import lbist_pkg::*;
#(
    parameter int PAT_W = 16,
    parameter int LEN_W = 10,
    parameter int CAP_W = 4,
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PAT_W-1:0] pat_count,
    input  logic [PAT_W-1:0] stop_after,
    input  logic [CAP_W-1:0] cap_len,
    input  logic [LEN_W-1:0] chan_len,
    input  logic [GAP_W-1:0] shift_gap,
    output logic             scan_en,
    output logic             cap_en,
    output logic             compress,
    output logic             restart,
    output logic             done
);
    seq_state_e       state;
    logic [PAT_W-1:0] pats_q, pat_idx, pc_eff, pats_eff;
    logic [LEN_W-1:0] len_q, shift_cnt;
    logic [CAP_W-1:0] caps_q, cap_cnt;
    logic [GAP_W-1:0] gap_q, gap_cnt;
    logic             last_shift;

    // Start acceptance and effective pattern count (stop point, zero -> 1)
    always_comb begin
        restart  = start && (state == ST_IDLE || state == ST_DONE);
        pc_eff   = (pat_count == '0) ? PAT_W'(1) : pat_count;
        pats_eff = (stop_after != '0 && stop_after < pc_eff) ? stop_after : pc_eff;
    end

    // Output strobes decoded from state and counters
    always_comb begin
        scan_en    = (state == ST_SHIFT) && (gap_cnt == gap_q);
        cap_en     = (state == ST_CAPT);
        compress   = scan_en && (pat_idx != '0);
        done       = (state == ST_DONE);
        last_shift = (shift_cnt == len_q - LEN_W'(1));
    end

    // Main sequence: shift passes, capture bursts, pattern counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pats_q    <= '0;
            pat_idx   <= '0;
            len_q     <= LEN_W'(1);
            shift_cnt <= '0;
            caps_q    <= CAP_W'(1);
            cap_cnt   <= '0;
            gap_q     <= '0;
            gap_cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (restart) begin
                        pats_q    <= pats_eff;
                        len_q     <= (chan_len == '0) ? LEN_W'(1) : chan_len;
                        caps_q    <= (cap_len == '0) ? CAP_W'(1) : cap_len;
                        gap_q     <= shift_gap;
                        pat_idx   <= '0;
                        shift_cnt <= '0;
                        gap_cnt   <= '0;
                        cap_cnt   <= '0;
                        state     <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (scan_en) begin
                        gap_cnt <= '0;
                        if (last_shift) begin
                            shift_cnt <= '0;
                            cap_cnt   <= '0;
                            state     <= (pat_idx == pats_q) ? ST_DONE : ST_CAPT;
                        end else begin
                            shift_cnt <= shift_cnt + LEN_W'(1);
                        end
                    end else begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                    end
                end
                ST_CAPT: begin
                    if (cap_cnt == caps_q - CAP_W'(1)) begin
                        pat_idx <= pat_idx + PAT_W'(1);
                        gap_cnt <= '0;
                        state   <= ST_SHIFT;
                    end else begin
                        cap_cnt <= cap_cnt + CAP_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: with a nonzero gap, no two shift pulses are adjacent
    a_r6_gap_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && gap_q != '0) |=> !scan_en);
    // R5: a capture burst begins only right after a shift pulse
    a_r5_cap_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_en) |-> $past(scan_en));
    // R8: finished state holds until a start arrives
    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    // R3: the shift after the final capture burst never leaves the run early
    a_r3_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(scan_en) && !$past(compress && pat_idx != pats_q));
endmodule

// File: rtl/lbist_ctrl.sv
// Top of the self-test sequencer: joins the pattern source, the run
// sequencer and the signature register. Assumes NUM_CH <= 32 and that the
// channels, reset and clock belong to the same domain.
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int PAT_W  = 16,
    parameter int LEN_W  = 10,
    parameter int CAP_W  = 4,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       seed,
    input  logic [PAT_W-1:0]  pat_count,
    input  logic [PAT_W-1:0]  stop_after,
    input  logic [CAP_W-1:0]  cap_len,
    input  logic [LEN_W-1:0]  chan_len,
    input  logic [GAP_W-1:0]  shift_gap,
    output logic [NUM_CH-1:0] scan_in,
    input  logic [NUM_CH-1:0] scan_out,
    output logic              scan_en,
    output logic              cap_en,
    output logic [31:0]       signature,
    output logic              done
);
    logic compress, restart;

    lbist_seq #(
        .PAT_W(PAT_W), .LEN_W(LEN_W), .CAP_W(CAP_W), .GAP_W(GAP_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pat_count(pat_count), .stop_after(stop_after),
        .cap_len(cap_len), .chan_len(chan_len), .shift_gap(shift_gap),
        .scan_en(scan_en), .cap_en(cap_en), .compress(compress),
        .restart(restart), .done(done)
    );

    lbist_prpg #(.NUM_CH(NUM_CH)) u_prpg (
        .clk(clk), .rst_n(rst_n), .load(restart), .seed(seed),
        .advance(scan_en), .chan_bits(scan_in)
    );

    lbist_misr #(.NUM_CH(NUM_CH)) u_misr (
        .clk(clk), .rst_n(rst_n), .clear(restart), .enable(compress),
        .din(scan_out), .sig(signature)
    );

    // R8: signature is frozen while finished and no start arrives
    a_r8_sig_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(signature));
    // R5: shift and capture strobes are never both active
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_en && cap_en));
endmodule

// File: tb/lbist_ctrl_bench.sv
// Self-checking bench: models four channels of logic under test around the
// sequencer and compares against an arithmetic model of the whole run.
module lbist_ctrl_bench;
    localparam int NCH   = 4;
    localparam int PAT_W = 4;
    localparam int LEN_W = 4;
    localparam int CAP_W = 3;
    localparam int GAP_W = 2;
    localparam int MAXL  = 16;
    localparam logic [31:0] TAPS = 32'h8020_0003;

    typedef logic [NCH-1:0] chain_t [MAXL];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] seed_i = '0;
    logic [PAT_W-1:0] pat_i = '0, stop_i = '0;
    logic [CAP_W-1:0] cap_i = '0;
    logic [LEN_W-1:0] len_i = '0;
    logic [GAP_W-1:0] gap_i = '0;
    logic [NCH-1:0] scan_in, scan_out;
    logic scan_en, cap_en, done;
    logic [31:0] signature;

    int compared = 0, mismatched = 0;
    int cur_len = 1;

    always #4 clk = ~clk;

    lbist_ctrl #(
        .NUM_CH(NCH), .PAT_W(PAT_W), .LEN_W(LEN_W), .CAP_W(CAP_W), .GAP_W(GAP_W)
    ) u_lbist_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed_i),
        .pat_count(pat_i), .stop_after(stop_i), .cap_len(cap_i),
        .chan_len(len_i), .shift_gap(gap_i), .scan_in(scan_in),
        .scan_out(scan_out), .scan_en(scan_en), .cap_en(cap_en),
        .signature(signature), .done(done)
    );

    // ---- logic-under-test model ----
    function automatic chain_t shift_step(chain_t c, int L, logic [NCH-1:0] din);
        chain_t n = c;
        for (int j = L - 1; j > 0; j--) n[j] = c[j-1];
        n[0] = din;
        return n;
    endfunction

    function automatic chain_t cap_step(chain_t c, int L);
        chain_t n = c;
        for (int j = 0; j < L; j++) begin
            logic [NCH-1:0] nb = c[(j + 1) % L];
            n[j] = c[j] ^ {nb[0], nb[NCH-1:1]} ^ NCH'(j + 1);
        end
        return n;
    endfunction

    chain_t ch;
    initial for (int j = 0; j < MAXL; j++) ch[j] = '0;
    always @(posedge clk) begin
        if (scan_en) ch <= shift_step(ch, cur_len, scan_in);
        else if (cap_en) ch <= cap_step(ch, cur_len);
    end
    assign scan_out = ch[cur_len-1];

    // ---- arithmetic model of a full run ----
    function automatic logic [31:0] golden(logic [31:0] sd, int P, int C, int L);
        chain_t c;
        logic [31:0] g = (sd == 32'd0) ? 32'd1 : sd;
        logic [31:0] m = 32'd0;
        for (int j = 0; j < MAXL; j++) c[j] = '0;
        for (int k = 0; k <= P; k++) begin
            for (int s = 0; s < L; s++) begin
                if (k > 0) m = {m[30:0], ^(m & TAPS)} ^ {{(32-NCH){1'b0}}, c[L-1]};
                c = shift_step(c, L, g[NCH-1:0]);
                g = {g[30:0], ^(g & TAPS)};
            end
            if (k < P) for (int t = 0; t < C; t++) c = cap_step(c, L);
        end
        return m;
    endfunction

    // ---- monitor, sampled at the falling edge ----
    int cyc = 0, n_scan = 0, n_cap = 0, run = 0, exp_cap = 1, exp_gap = 0;
    int run_err = 0, ovl_err = 0, gap_err = 0, lat_err = 0, prev_scan = 0;
    int last_scan = 0;
    bit have_prev = 0, cap_between = 0, first_seen = 0, done_q = 0;
    logic [NCH-1:0] first_in = '0;

    always @(negedge clk) begin
        cyc++;
        if (scan_en) begin
            n_scan++;
            if (!first_seen) begin first_in = scan_in; first_seen = 1; end
            if (have_prev && !cap_between && (cyc - prev_scan) != exp_gap + 1) gap_err++;
            have_prev = 1; cap_between = 0; prev_scan = cyc; last_scan = cyc;
        end
        if (cap_en) begin
            n_cap++; run++; cap_between = 1;
            if (scan_en) ovl_err++;
        end else if (run != 0) begin
            if (run != exp_cap) run_err++;
            run = 0;
        end
        if (done && !done_q && (cyc - last_scan) != 1) lat_err++;
        done_q = done;
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic mon_clear(int C, int G);
        n_scan = 0; n_cap = 0; run = 0; run_err = 0; ovl_err = 0; gap_err = 0;
        lat_err = 0; have_prev = 0; cap_between = 0; first_seen = 0;
        exp_cap = C; exp_gap = G;
    endtask

    // One full run with checks; sig_req names the requirement for the signature
    task automatic run_case(logic [31:0] sd, int P, int stp, int C, int L, int G,
                            bit perturb, string sig_req);
        int pe, ce, le, waited;
        logic [31:0] exp_sig, sd_eff;
        pe = (P == 0) ? 1 : P;
        if (stp != 0 && stp < pe) pe = stp;
        ce = (C == 0) ? 1 : C;
        le = (L == 0) ? 1 : L;
        sd_eff = (sd == 32'd0) ? 32'd1 : sd;
        exp_sig = golden(sd, pe, ce, le);
        @(negedge clk);
        seed_i = sd; pat_i = PAT_W'(P); stop_i = PAT_W'(stp);
        cap_i = CAP_W'(C); len_i = LEN_W'(L); gap_i = GAP_W'(G);
        cur_len = le;
        mon_clear(ce, G);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R8", "done cleared by start", done, 0);
        if (perturb) begin
            repeat (6) @(negedge clk);
            seed_i = 32'h5; pat_i = 1; stop_i = 1; cap_i = 3; len_i = 2; gap_i = 1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 20000) begin @(negedge clk); waited++; end
        check(done == 1'b1, "R8", "run finished", done, 1);
        check(signature == exp_sig, sig_req, "signature", signature, exp_sig);
        check(n_scan == (pe + 1) * le, "R3", "shift pulse count", n_scan, (pe + 1) * le);
        check(n_cap == pe * ce, "R5", "capture cycle count", n_cap, pe * ce);
        check(run_err == 0 && ovl_err == 0, "R5", "burst shape errors", run_err + ovl_err, 0);
        check(gap_err == 0, "R6", "shift spacing errors", gap_err, 0);
        check(lat_err == 0, "R8", "done latency errors", lat_err, 0);
        check(first_in == sd_eff[NCH-1:0], "R2", "first channel bits", first_in, sd_eff[NCH-1:0]);
    endtask

    // Global watchdog: an expired run is a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        mismatched++; compared++;
        $display("FAIL R8 watchdog: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int idx = 0;
        logic [31:0] held;
        int held_scan, held_cap;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 0 && scan_en == 0 && cap_en == 0, "R1", "reset strobes",
              {done, scan_en, cap_en}, 0);
        check(signature == 32'd0, "R1", "reset signature", signature, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Sweep: patterns x burst x length x gap (R2, R3, R4, R5, R6)
        for (int p = 1; p <= 3; p++)
            for (int ci = 0; ci < 3; ci++)
                for (int l = 1; l <= 5; l += 2)
                    for (int g = 0; g <= 2; g += 2) begin
                        run_case(32'h1234_5678 + 32'(idx) * 32'h9E37_79B9,
                                 p, 0, 1 << ci, l, g, 1'b0, "R4");
                        idx++;
                    end

        // R2: zero seed behaves as seed 1
        run_case(32'd0, 2, 0, 2, 3, 0, 1'b0, "R2");
        // R3 and R5: zero-valued settings count as 1
        run_case(32'hCAFE_0001, 0, 0, 0, 0, 1, 1'b0, "R3");
        run_case(32'hBEEF_0042, 2, 0, 0, 4, 0, 1'b0, "R5");
        // R7: stop below, at and above the pattern count
        run_case(32'h0F0F_1234, 5, 2, 2, 4, 1, 1'b0, "R7");
        run_case(32'h0F0F_1234, 4, 4, 3, 3, 0, 1'b0, "R7");
        run_case(32'h7777_0003, 4, 9, 1, 5, 0, 1'b0, "R7");
        // R9: inputs changed and start pulsed mid-run
        run_case(32'hA5A5_5A5A, 3, 0, 3, 5, 2, 1'b1, "R9");

        // R8: hold after finish
        held = signature; held_scan = n_scan; held_cap = n_cap;
        repeat (25) @(negedge clk);
        check(done == 1'b1, "R8", "done held", done, 1);
        check(signature == held, "R8", "signature held", signature, held);
        check(n_scan == held_scan && n_cap == held_cap, "R8", "strobes quiet after done",
              n_scan + n_cap, held_scan + held_cap);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule